// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the bus side of a serial memory. A system clock oversamples a mode-0 serial link: the bus clock idles low, input data is captured on its rising edge and output data changes on its falling edge. The block does not drive the bus clock. Input data and output data use separate pins, and each byte moves most significant bit first. A falling edge of the select line starts a sequence. The first byte is decoded as a command. The block then accepts data bytes and hands them to a memory back end through single-cycle strobes, or it shifts bytes out that come from the back end or from its own status register.

The block has two bus controls besides select. A pause input holds a sequence in place while the bus is used for something else. A protect pin, together with a protect-enable bit in the status register, decides whether status writes are allowed. Each committed write starts a busy interval of programmable length, which stands in for the nonvolatile write time. Write commands that arrive during that interval are refused.

The controller states are IDLE (deselected or waiting), OPCODE (command byte arriving), RX (data bytes arriving), TX (data bytes leaving) and LOCK (refused or unknown command). The transitions are as follows. Any state goes to IDLE when select is high. Any state goes to OPCODE on a select falling edge. OPCODE goes to RX after an accepted write command and to TX after an accepted read command. OPCODE goes to LOCK after an unknown command or a write command refused while busy.

Top module: `spimem_front`

## Requirements
- R1: Bytes in both directions are shifted most significant bit first. The first complete byte after a select falling edge is the command.
- R2: Command codes are 0x01 status write, 0x02 data write, 0x03 data read and 0x05 status read. An accepted command gives a one-cycle `cmd_stb` pulse with the code on `cmd_op`.
- R3: Any other command code sends the block to LOCK. In LOCK there are no strobes and `so_oe` stays low until the next select falling edge, after which commands decode normally.
- R4: While select is high, `so_oe` is low and input data is ignored. A partial command byte cut off by select going high is discarded.
- R5: A pause begins only when `hold_n` falls while the bus clock is low. A fall of `hold_n` while the bus clock is high does not pause. A pause ends when `hold_n` is high while the bus clock is low.
- R6: During a pause, `so_oe` is low and bus clock edges and input data are ignored. The bit position is kept, so the sequence resumes at the bit where it stopped.
- R7: A status read returns {status bits 7..1, busy}. The first data byte of a status write loads status bits 7..1. Bit 7 is the protect-enable bit.
- R8: When `wp_n` is low and bit 7 is 1, a status write changes nothing and does not start busy. When bit 7 is 0, `wp_n` has no effect.
- R9: A status write that has already been committed is not undone when `wp_n` falls afterwards.
- R10: Each committed write byte (data write byte, or allowed status write) holds `busy` high for WR_CYCLES system clocks. A write command decoded while busy goes to LOCK.
- R11: In a data read, `rd_req` pulses at the start of each output byte slot. `rd_data` is sampled at the next bus clock falling edge and shifted out.
- R12: Each completed data write byte pulses `wr_stb` with the byte on `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Bus select, active low |
| sck | input | 1 | Bus clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Status write protect pin, active low |
| rd_data | input | 8 | Byte from the back end for data reads |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (low means high impedance) |
| cmd_stb | output | 1 | Accepted command pulse |
| cmd_op | output | 8 | Accepted command code |
| wr_stb | output | 1 | Data write byte pulse |
| wr_data | output | 8 | Data write byte |
| rd_req | output | 1 | Request for the next read byte |
| busy | output | 1 | Write cycle in progress |

## Verification
Each of the four command codes is exercised, together with an unknown code and a command cut off after three bits. The cut-off command shows whether leftover bits leak into the next decode. Status writes are tried under all protect-pin and protect-bit combinations, and with the pin dropped after commit, which separates blocking from late aborts. Pauses are placed inside a command byte and inside an output byte, with junk clock edges in between, to show that the bit position is kept. A pause request raised while the bus clock is high shows that pause entry depends on the clock level. A second write command inside the busy window checks refusal.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_DATA_WR = 8'h02;
    localparam logic [7:0] OP_DATA_RD = 8'h03;
    localparam logic [7:0] OP_STAT_RD = 8'h05;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPCODE = 3'd1,
        ST_RX     = 3'd2,
        ST_TX     = 3'd3,
        ST_LOCK   = 3'd4
    } st_e;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RST;
        else        pipe[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RST;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spimem_hold.sv
module spimem_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sck_s,
    input  logic hold_s,
    output logic paused
);
    logic hold_q;
    logic hold_fall;

    assign hold_fall = hold_q & ~hold_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b1;
            paused <= 1'b0;
        end else begin
            hold_q <= hold_s;
            if (!active)
                paused <= 1'b0;
            else if (!paused && hold_fall && !sck_s)
                paused <= 1'b1;
            else if (paused && hold_s && !sck_s)
                paused <= 1'b0;
        end
    end
endmodule

// File: rtl/spimem_busy.sv
module spimem_busy #(
    parameter int unsigned CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/spimem_front.sv
module spimem_front
    import spimem_pkg::*;
#(
    parameter int unsigned WR_CYCLES   = 1000000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic       hold_n,
    input  logic       wp_n,
    input  logic [7:0] rd_data,
    output logic       so,
    output logic       so_oe,
    output logic       cmd_stb,
    output logic [7:0] cmd_op,
    output logic       wr_stb,
    output logic [7:0] wr_data,
    output logic       rd_req,
    output logic       busy
);
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned BIT_CNT_W = $clog2(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic cs_s, sck_s, si_s, hold_s, wp_s;
    logic sck_q, cs_q;
    logic paused;
    logic sck_rise, sck_fall, cs_fall, byte_done;
    logic [BIT_CNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0]    rx, tx, rx_byte, op_q;
    logic [BYTE_W-2:0]    stat_hi;
    logic sr_first, wr_go;
    logic op_known, op_is_wr, op_accept;
    st_e  state, nxt;

    spimem_sync #(.W(5), .STAGES(SYNC_STAGES), .RST(5'b10011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sck, si, hold_n, wp_n}),
        .dout  ({cs_s, sck_s, si_s, hold_s, wp_s})
    );

    spimem_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (~cs_s),
        .sck_s  (sck_s),
        .hold_s (hold_s),
        .paused (paused)
    );

    spimem_busy #(.CYCLES(WR_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_go),
        .busy  (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_s;
        end
    end

    assign sck_rise  = sck_s & ~sck_q & ~paused & ~cs_s;
    assign sck_fall  = ~sck_s & sck_q & ~paused & ~cs_s;
    assign cs_fall   = ~cs_s & cs_q;
    assign byte_done = sck_rise && (bitcnt == LAST_BIT);
    assign rx_byte   = {rx[BYTE_W-2:0], si_s};

    assign op_known  = (rx_byte == OP_STAT_WR) || (rx_byte == OP_DATA_WR) ||
                       (rx_byte == OP_DATA_RD) || (rx_byte == OP_STAT_RD);
    assign op_is_wr  = (rx_byte == OP_STAT_WR) || (rx_byte == OP_DATA_WR);
    assign op_accept = op_known && !(op_is_wr && busy);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (cs_s)
            nxt = ST_IDLE;
        else if (cs_fall)
            nxt = ST_OPCODE;
        else begin
            unique case (state)
                ST_IDLE:   nxt = ST_IDLE;
                ST_OPCODE: begin
                    if (byte_done) begin
                        if (!op_accept)
                            nxt = ST_LOCK;
                        else if (op_is_wr)
                            nxt = ST_RX;
                        else
                            nxt = ST_TX;
                    end
                end
                ST_RX:     nxt = ST_RX;
                ST_TX:     nxt = ST_TX;
                ST_LOCK:   nxt = ST_LOCK;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            rx       <= '0;
            tx       <= '0;
            op_q     <= '0;
            sr_first <= 1'b0;
        end else if (cs_s || cs_fall) begin
            bitcnt <= '0;
            rx     <= '0;
        end else begin
            if (sck_rise && state != ST_LOCK && state != ST_IDLE) begin
                rx     <= rx_byte;
                bitcnt <= bitcnt + 1'b1;
                if (state == ST_OPCODE && byte_done) begin
                    op_q     <= rx_byte;
                    sr_first <= 1'b1;
                end else if (state == ST_RX && byte_done) begin
                    sr_first <= 1'b0;
                end
            end
            if (sck_fall && state == ST_TX) begin
                if (bitcnt == '0)
                    tx <= (op_q == OP_STAT_RD) ? {stat_hi, busy} : rd_data;
                else
                    tx <= {tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign so = tx[BYTE_W-1];

    // outputs and status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_stb <= 1'b0;
            cmd_op  <= '0;
            wr_stb  <= 1'b0;
            wr_data <= '0;
            rd_req  <= 1'b0;
            wr_go   <= 1'b0;
            so_oe   <= 1'b0;
            stat_hi <= '0;
        end else begin
            cmd_stb <= 1'b0;
            wr_stb  <= 1'b0;
            rd_req  <= 1'b0;
            wr_go   <= 1'b0;
            so_oe   <= (state == ST_TX) && !paused && !cs_s;
            if (byte_done && !cs_fall) begin
                unique case (state)
                    ST_OPCODE: begin
                        if (op_accept) begin
                            cmd_stb <= 1'b1;
                            cmd_op  <= rx_byte;
                            rd_req  <= (rx_byte == OP_DATA_RD);
                        end
                    end
                    ST_RX: begin
                        if (op_q == OP_DATA_WR) begin
                            wr_stb  <= 1'b1;
                            wr_data <= rx_byte;
                            wr_go   <= 1'b1;
                        end else if (sr_first && !(stat_hi[BYTE_W-2] && !wp_s)) begin
                            stat_hi <= rx_byte[BYTE_W-1:1];
                            wr_go   <= 1'b1;
                        end
                    end
                    ST_TX:   rd_req <= (op_q == OP_DATA_RD);
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spimem_front_chk.sv
module spimem_front_chk
    import spimem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s,
    input logic       sck_s,
    input logic       wp_s,
    input logic       paused,
    input logic       so_oe,
    input logic [2:0] state,
    input logic       byte_done,
    input logic [2:0] bitcnt,
    input logic [7:0] rx,
    input logic [7:0] rx_byte,
    input logic [7:0] op_q,
    input logic [6:0] stat_hi,
    input logic       busy,
    input logic       cmd_stb,
    input logic       wr_stb
);
    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !so_oe); // R4

    AST_PAUSE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> !so_oe); // R6

    AST_PAUSE_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !cs_s) |=> ($stable(bitcnt) && $stable(rx))); // R6

    AST_PAUSE_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(!sck_s)); // R5

    AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK) |-> (!cmd_stb && !wr_stb && !so_oe)); // R3

    AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state == ST_RX && op_q == OP_STAT_WR && stat_hi[6] && !wp_s)
        |=> $stable(stat_hi)); // R8

    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state == ST_OPCODE && busy &&
         (rx_byte == OP_STAT_WR || rx_byte == OP_DATA_WR))
        |=> (state == ST_LOCK || state == ST_OPCODE)); // R10

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb, wr_stb})); // R2
endmodule

bind spimem_front spimem_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .sck_s     (sck_s),
    .wp_s      (wp_s),
    .paused    (paused),
    .so_oe     (so_oe),
    .state     (state),
    .byte_done (byte_done),
    .bitcnt    (bitcnt),
    .rx        (rx),
    .rx_byte   (rx_byte),
    .op_q      (op_q),
    .stat_hi   (stat_hi),
    .busy      (busy),
    .cmd_stb   (cmd_stb),
    .wr_stb    (wr_stb)
);

// File: tb/spimem_front_tb_top.sv
module spimem_front_tb_top;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic [7:0] rd_data = 8'h00;
    logic so, so_oe, cmd_stb, wr_stb, rd_req, busy;
    logic [7:0] cmd_op, wr_data;

    int nvec = 0, nfail = 0, nstrobe = 0;
    int rd_cnt = 0;
    logic [8:0] exp_q [$];

    always #2.5 clk = ~clk;

    spimem_front #(.WR_CYCLES(300)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .rd_data(rd_data), .so(so),
        .so_oe(so_oe), .cmd_stb(cmd_stb), .cmd_op(cmd_op), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_req(rd_req), .busy(busy)
    );

    // read back end model
    always @(negedge clk) begin
        if (cs_n) rd_cnt <= 0;
        else if (rd_req) begin
            rd_data <= 8'hA0 + 8'(rd_cnt);
            rd_cnt  <= rd_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (cmd_stb || wr_stb)) begin
            logic [8:0] got;
            got = {wr_stb, wr_stb ? wr_data : cmd_op};
            nstrobe++;
            if (exp_q.size() == 0) begin
                nvec++; nfail++;
                $display("FAIL R2/R10 unexpected strobe act=%h exp=none", got);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk("R2/R12 strobe", got[7:0], e[7:0]);
                chk("R2/R12 kind", {7'd0, got[8]}, {7'd0, e[8]});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic o, output logic oe);
        si = b;
        tick(HP);
        o = so; oe = so_oe;
        sck = 1'b1;
        tick(HP);
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] d, output logic [7:0] q, output logic oe_all);
        logic o, oe;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bit_x(d[i], o, oe);
            q[i] = o;
            oe_all &= oe;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0; tick(HP);
    endtask

    task automatic cs_hi();
        tick(HP); cs_n = 1'b1; tick(3 * HP);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000 && busy; i++) tick(1);
    endtask

    task automatic stat_rd(input string tag, input logic [7:0] exp);
        logic [7:0] q; logic oe;
        exp_q.push_back({1'b0, 8'h05});
        cs_lo(); xfer(8'h05, q, oe); xfer(8'h00, q, oe);
        chk(tag, q, exp);
        chk({tag, " oe"}, {7'd0, oe}, 8'd1);
        cs_hi();
    endtask

    task automatic stat_wr(input logic [7:0] v);
        logic [7:0] q; logic oe;
        exp_q.push_back({1'b0, 8'h01});
        cs_lo(); xfer(8'h01, q, oe); xfer(v, q, oe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nvec++; nfail++;
        $display("FAIL watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [7:0] q, q2; logic oe, o;
        int s0;
        tick(10); rst_n = 1'b1; tick(4);

        // R4 reset state
        chk("R4 reset so_oe", {7'd0, so_oe}, 8'd0);
        chk("R10 reset busy", {7'd0, busy}, 8'd0);

        // R7 status read after reset, R1 ordering
        stat_rd("R7 status reset", 8'h00);
        chk("R4 so_oe after deselect", {7'd0, so_oe}, 8'd0);

        // R7/R10 status write, busy in bit 0
        stat_wr(8'h8C); cs_hi();
        chk("R10 busy after commit", {7'd0, busy}, 8'd1);
        stat_rd("R7 status with busy", 8'h8D);
        wait_idle();
        stat_rd("R7 status idle", 8'h8C);

        // R8 protect pin low with enable bit set
        wp_n = 1'b0; tick(4);
        stat_wr(8'h02); cs_hi();
        chk("R8 blocked no busy", {7'd0, busy}, 8'd0);
        stat_rd("R8 blocked status", 8'h8C);

        // R9 pin falls after commit
        wp_n = 1'b1; tick(4);
        stat_wr(8'h86); wp_n = 1'b0; cs_hi();
        wait_idle();
        stat_rd("R9 committed kept", 8'h86);

        // R8 enable bit clear: pin ignored
        wp_n = 1'b1; tick(4);
        stat_wr(8'h04); cs_hi(); wait_idle();
        wp_n = 1'b0; tick(4);
        stat_wr(8'h12); cs_hi(); wait_idle();
        stat_rd("R8 pin ignored", 8'h12);
        wp_n = 1'b1;

        // R12 data write, R10 refusal while busy
        exp_q.push_back({1'b0, 8'h02});
        exp_q.push_back({1'b1, 8'h55});
        exp_q.push_back({1'b1, 8'hAA});
        cs_lo(); xfer(8'h02, q, oe); xfer(8'h55, q, oe); xfer(8'hAA, q, oe); cs_hi();
        chk("R10 busy after data write", {7'd0, busy}, 8'd1);
        s0 = nstrobe;
        cs_lo(); xfer(8'h02, q, oe); xfer(8'h66, q, oe); cs_hi();
        chk("R10 refused no strobe", 8'(nstrobe - s0), 8'd0);
        chk("R10 refused so_oe", {7'd0, oe}, 8'd0);
        wait_idle();

        // R3 unknown command lockout then restart
        s0 = nstrobe;
        cs_lo(); xfer(8'hFF, q, oe); xfer(8'h05, q, oe); xfer(8'h00, q2, o); cs_hi();
        chk("R3 lock so_oe", {7'd0, oe | o}, 8'd0);
        chk("R3 lock no strobe", 8'(nstrobe - s0), 8'd0);
        stat_rd("R3 restart", 8'h12);

        // R4 partial command discarded
        cs_lo(); bit_x(1'b1, o, oe); bit_x(1'b1, o, oe); bit_x(1'b1, o, oe); cs_hi();
        stat_rd("R4 partial discarded", 8'h12);

        // R11 data read
        exp_q.push_back({1'b0, 8'h03});
        cs_lo(); xfer(8'h03, q, oe); xfer(8'h00, q, oe); xfer(8'h00, q2, o); cs_hi();
        chk("R11 read byte0", q, 8'hA0);
        chk("R11 read byte1", q2, 8'hA1);

        // R6 pause inside command byte
        exp_q.push_back({1'b0, 8'h05});
        cs_lo();
        for (int i = 0; i < 4; i++) bit_x(1'b0, o, oe);
        hold_n = 1'b0; tick(HP);
        for (int i = 0; i < 3; i++) begin
            si = 1'b1; sck = 1'b1; tick(HP); sck = 1'b0; tick(HP);
        end
        chk("R6 paused so_oe", {7'd0, so_oe}, 8'd0);
        hold_n = 1'b1; tick(HP);
        bit_x(1'b0, o, oe); bit_x(1'b1, o, oe); bit_x(1'b0, o, oe); bit_x(1'b1, o, oe);
        xfer(8'h00, q, oe); cs_hi();
        chk("R6 resume command", q, 8'h12);

        // R6 pause inside output byte
        exp_q.push_back({1'b0, 8'h05});
        cs_lo(); xfer(8'h05, q, oe);
        for (int i = 7; i >= 4; i--) begin bit_x(1'b0, o, oe); q[i] = o; end
        hold_n = 1'b0; tick(HP);
        for (int i = 0; i < 2; i++) begin
            si = 1'b1; sck = 1'b1; tick(HP); sck = 1'b0; tick(HP);
        end
        chk("R6 paused output oe", {7'd0, so_oe}, 8'd0);
        hold_n = 1'b1; tick(HP);
        for (int i = 3; i >= 0; i--) begin bit_x(1'b0, o, oe); q[i] = o; end
        cs_hi();
        chk("R6 resume output", q, 8'h12);

        // R5 hold falls while bus clock high: no pause
        exp_q.push_back({1'b0, 8'h03});
        cs_lo(); xfer(8'h03, q, oe);
        si = 1'b0; tick(HP); q[7] = so; oe = so_oe;
        sck = 1'b1; tick(2); hold_n = 1'b0; tick(HP - 2); sck = 1'b0;
        for (int i = 6; i >= 0; i--) begin bit_x(1'b0, o, q2[0]); q[i] = o; oe &= q2[0]; end
        chk("R5 no pause byte", q, 8'hA0);
        chk("R5 no pause oe", {7'd0, oe}, 8'd1);
        hold_n = 1'b1; cs_hi();

        chk("R2 scoreboard drained", 8'(exp_q.size()), 8'd0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule